// File: doc/BRIEF.md
# Phase-Frequency Comparator with Filtered Lock Flag

This block compares a reference pulse train against the divided-down oscillator pulse train of a frequency synthesizer loop. Both inputs are synchronous to the system clock. A comparison starts at the first rising edge seen on either input and ends at the first rising edge of the other input. While a comparison is open, two complementary three-state error outputs drive an external active loop filter. Each output is modelled as an enable and a level. The plain output drives high when the reference leads and low when the oscillator leads. The inverted output does the opposite. Between comparisons both outputs float. The width of each error pulse, in clock cycles, equals the distance between the two edges.

A lock flag reports a settled loop. It goes high only after a run of consecutive comparisons whose error width stays within a small tolerance. It is forced low in every cycle in which an error pulse is being driven. The comparator has three states: `CMP_IDLE`, `CMP_LEAD` (reference first) and `CMP_LAG` (oscillator first). The transitions are IDLE→LEAD on a reference edge alone, IDLE→LAG on an oscillator edge alone, LEAD→IDLE on an oscillator edge, LAG→IDLE on a reference edge, and IDLE→IDLE on coincident edges, which close a comparison of width zero. The lock filter also has three states: `LK_SEARCH`, `LK_QUALIFY` and `LK_HELD`. A good comparison moves it SEARCH→QUALIFY and QUALIFY→HELD once the run is complete, and keeps it in HELD. A wide comparison returns it from any state to SEARCH.

Top module: `phase_cmp_lock`

## Requirements
- R1: After reset both error outputs float (both enables 0) and `locked` is 0.
- R2: A reference rising edge sampled while idle makes `p_out` drive high (en=1, lvl=1) and `n_out` drive low (en=1, lvl=0) from the next cycle. The drive lasts exactly as many cycles as separate the reference edge from the oscillator edge that ends it.
- R3: An oscillator rising edge sampled while idle makes `p_out` drive low and `n_out` drive high. The drive lasts exactly the edge separation in cycles.
- R4: Reference and oscillator rising edges sampled in the same cycle while idle produce no error pulse. This counts as a comparison of width 0.
- R5: Further rising edges of the leading input while its pulse is open are ignored. The pulse ends only on the other input's edge.
- R6: `locked` is 0 in every cycle in which the error outputs are enabled.
- R7: `locked` goes to 1 in the cycle after the closing edge of the 4th (LOCK_RUNS) consecutive comparison whose width is at most 2 (TOL_CYC) cycles.
- R8: A comparison wider than TOL_CYC clears the run and clears lock. Lock then needs LOCK_RUNS new good comparisons.
- R9: Only rising edges act. An input held high starts no new comparison.
- R10: The two enables are always equal, and when enabled their levels are opposite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | Reference pulse train |
| fb_pulse | input | 1 | Divided oscillator pulse train |
| p_out_en | output | 1 | Plain error output drive enable |
| p_out_lvl | output | 1 | Plain error output level (high = reference leads) |
| n_out_en | output | 1 | Inverted error output drive enable |
| n_out_lvl | output | 1 | Inverted error output level (high = oscillator leads) |
| locked | output | 1 | Lock flag, high when settled and no pulse is active |

## Verification
The comparator is swept over every edge separation from 0 to 7 cycles, with the reference leading and with the oscillator leading. Each sweep point measures the pulse width, the polarity of both outputs, and the lock flag during the pulse. Separations of three cycles or more also carry an extra mid-pulse edge on the leading input. This shows whether a repeated edge restarts or ends the pulse. Inputs are left high after each comparison, which separates edge detection from level sensing. A scripted run of narrow and wide separations is checked against an arithmetic run counter. This catches an off-by-one in the run length, a wrong tolerance bound, and a failure to clear lock after a wide error.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        CMP_IDLE,
        CMP_LEAD,
        CMP_LAG
    } cmp_state_t;

    typedef enum logic [1:0] {
        LK_SEARCH,
        LK_QUALIFY,
        LK_HELD
    } lock_state_t;

    typedef struct packed {
        logic en;
        logic lvl;
    } tri_drive_t;

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_in;
    end

    assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/pfd_compare.sv
module pfd_compare
    import pfd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise,
    input  logic             fb_rise,
    output cmp_state_t       state,
    output logic             cmp_done,
    output logic [CNT_W-1:0] cmp_width
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cmp_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMP_IDLE;
        else        state_q <= state_d;
    end

    // next state and comparison-complete strobe
    always_comb begin
        state_d   = state_q;
        cmp_done  = 1'b0;
        cmp_width = cnt_q;
        unique case (state_q)
            CMP_IDLE: begin
                if (ref_rise && fb_rise) begin
                    cmp_done  = 1'b1;
                    cmp_width = '0;
                end else if (ref_rise) begin
                    state_d = CMP_LEAD;
                end else if (fb_rise) begin
                    state_d = CMP_LAG;
                end
            end
            CMP_LEAD: begin
                if (fb_rise) begin
                    state_d  = CMP_IDLE;
                    cmp_done = 1'b1;
                end
            end
            CMP_LAG: begin
                if (ref_rise) begin
                    state_d  = CMP_IDLE;
                    cmp_done = 1'b1;
                end
            end
            default: state_d = CMP_IDLE;
        endcase
    end

    // pulse width counter: holds the number of cycles the pulse has been open
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == CMP_IDLE) begin
            cnt_q <= (state_d != CMP_IDLE) ? CNT_W'(1) : '0;
        end else if (state_d != CMP_IDLE) begin
            cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter
    import pfd_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int LOCK_RUNS = 4,
    parameter int TOL_CYC   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_done,
    input  logic [CNT_W-1:0] cmp_width,
    output logic             held
);
    localparam int RUN_W = $clog2(LOCK_RUNS + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUNS - 1);
    localparam logic [CNT_W-1:0] TOL_V = CNT_W'(TOL_CYC);

    lock_state_t      lk_q, lk_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic             good;

    assign good = cmp_width <= TOL_V;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q  <= LK_SEARCH;
            run_q <= '0;
        end else begin
            lk_q  <= lk_d;
            run_q <= run_d;
        end
    end

    // transitions
    always_comb begin
        lk_d  = lk_q;
        run_d = run_q;
        if (cmp_done) begin
            if (!good) begin
                lk_d  = LK_SEARCH;
                run_d = '0;
            end else begin
                unique case (lk_q)
                    LK_SEARCH: begin
                        if (LOCK_RUNS <= 1) lk_d = LK_HELD;
                        else                lk_d = LK_QUALIFY;
                        run_d = RUN_W'(1);
                    end
                    LK_QUALIFY: begin
                        if (run_q >= RUN_LAST) lk_d = LK_HELD;
                        run_d = run_q + RUN_W'(1);
                    end
                    LK_HELD: begin
                        lk_d = LK_HELD;
                    end
                    default: begin
                        lk_d  = LK_SEARCH;
                        run_d = '0;
                    end
                endcase
            end
        end
    end

    // output
    always_comb held = (lk_q == LK_HELD);
endmodule

// File: rtl/pfd_drive.sv
module pfd_drive
    import pfd_pkg::*;
#(
    parameter bit INVERT = 1'b0
) (
    input  cmp_state_t state,
    output tri_drive_t drv
);
    always_comb begin
        unique case (state)
            CMP_LEAD: drv = '{en: 1'b1, lvl: ~INVERT};
            CMP_LAG:  drv = '{en: 1'b1, lvl:  INVERT};
            default:  drv = '{en: 1'b0, lvl: 1'b0};
        endcase
    end
endmodule

// File: rtl/phase_cmp_lock.sv
module phase_cmp_lock
    import pfd_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int LOCK_RUNS = 4,
    parameter int TOL_CYC   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic fb_pulse,
    output logic p_out_en,
    output logic p_out_lvl,
    output logic n_out_en,
    output logic n_out_lvl,
    output logic locked
);
    localparam int N_IN  = 2;
    localparam int N_OUT = 2;

    logic [N_IN-1:0]  raw_in;
    logic [N_IN-1:0]  rise;
    cmp_state_t       state;
    logic             cmp_done;
    logic [CNT_W-1:0] cmp_width;
    logic             held;
    tri_drive_t       drv [N_OUT];

    assign raw_in = {fb_pulse, ref_pulse};

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_edge
        pfd_edge_det u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_in (raw_in[gi]),
            .rise   (rise[gi])
        );
    end

    pfd_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_rise  (rise[0]),
        .fb_rise   (rise[1]),
        .state     (state),
        .cmp_done  (cmp_done),
        .cmp_width (cmp_width)
    );

    pfd_lock_filter #(
        .CNT_W     (CNT_W),
        .LOCK_RUNS (LOCK_RUNS),
        .TOL_CYC   (TOL_CYC)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_done  (cmp_done),
        .cmp_width (cmp_width),
        .held      (held)
    );

    for (genvar go = 0; go < N_OUT; go++) begin : g_drv
        pfd_drive #(.INVERT(go[0])) u_drv (
            .state (state),
            .drv   (drv[go])
        );
    end

    assign p_out_en  = drv[0].en;
    assign p_out_lvl = drv[0].lvl;
    assign n_out_en  = drv[1].en;
    assign n_out_lvl = drv[1].lvl;
    assign locked    = held & (state == CMP_IDLE);
endmodule

// File: rtl/phase_cmp_lock_chk.sv
module phase_cmp_lock_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_pulse,
    input logic fb_pulse,
    input logic p_out_en,
    input logic p_out_lvl,
    input logic n_out_en,
    input logic n_out_lvl,
    input logic locked
);
    logic ref_q, fb_q, ref_up, fb_up;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
            fb_q  <= 1'b0;
        end else begin
            ref_q <= ref_pulse;
            fb_q  <= fb_pulse;
        end
    end

    assign ref_up = ref_pulse & ~ref_q;
    assign fb_up  = fb_pulse & ~fb_q;

    assert_enables_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (p_out_en == n_out_en) && (!p_out_en || (p_out_lvl != n_out_lvl)));

    assert_no_lock_in_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        p_out_en |-> !locked);

    assert_lead_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (p_out_en && p_out_lvl && !fb_up) |=> (p_out_en && p_out_lvl));

    assert_lag_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (p_out_en && !p_out_lvl && !ref_up) |=> (p_out_en && !p_out_lvl));

    assert_coincident_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_out_en && ref_up && fb_up) |=> !p_out_en);
endmodule

bind phase_cmp_lock phase_cmp_lock_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_pulse (ref_pulse),
    .fb_pulse  (fb_pulse),
    .p_out_en  (p_out_en),
    .p_out_lvl (p_out_lvl),
    .n_out_en  (n_out_en),
    .n_out_lvl (n_out_lvl),
    .locked    (locked)
);

// File: tb/sim_phase_cmp_lock.sv
module sim_phase_cmp_lock;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pulse = 1'b0;
    logic fb_pulse = 1'b0;
    logic p_out_en, p_out_lvl, n_out_en, n_out_lvl, locked;

    int n_chk = 0;
    int n_fail = 0;
    int run = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    phase_cmp_lock u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .fb_pulse  (fb_pulse),
        .p_out_en  (p_out_en),
        .p_out_lvl (p_out_lvl),
        .n_out_en  (n_out_en),
        .n_out_lvl (n_out_lvl),
        .locked    (locked)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One comparison: leading input rises, the other follows d cycles later.
    task automatic do_cmp(input bit ref_first, input int d, input bit extra);
        int active = 0;
        int pol_bad = 0;
        int lock_bad = 0;
        int exp_lvl = ref_first ? 1 : 0;
        @(negedge clk);
        if (d == 0) begin
            ref_pulse = 1'b1;
            fb_pulse  = 1'b1;
        end else if (ref_first) ref_pulse = 1'b1;
        else fb_pulse = 1'b1;
        for (int c = 1; c <= d + 3; c++) begin
            @(negedge clk);
            if (p_out_en) begin
                active++;
                if (p_out_lvl != exp_lvl[0] || !n_out_en || n_out_lvl == exp_lvl[0]) pol_bad++;
                if (locked) lock_bad++;
            end else if (n_out_en) pol_bad++;
            if (extra && c == 1) begin
                if (ref_first) ref_pulse = 1'b0; else fb_pulse = 1'b0;
            end
            if (extra && c == 2) begin
                if (ref_first) ref_pulse = 1'b1; else fb_pulse = 1'b1;
            end
            if (d > 0 && c == d) begin
                if (ref_first) fb_pulse = 1'b1; else ref_pulse = 1'b1;
            end
        end
        // inputs left high for the trailing cycles: R9 (no new pulse from a held level)
        if (d == 0) check("R4 width", active, 0);
        else if (extra) check("R5 width with extra lead edge", active, d);
        else if (ref_first) check("R2/R9 width", active, d);
        else check("R3/R9 width", active, d);
        check("R10 polarity", pol_bad, 0);
        check("R6 lock during pulse", lock_bad, 0);
        if (d <= 2) run++; else run = 0;
        check((d <= 2) ? "R7 lock after run" : "R8 lock cleared", int'(locked), (run >= 4) ? 1 : 0);
        ref_pulse = 1'b0;
        fb_pulse  = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_fail++;
                n_chk++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 p enable", int'(p_out_en), 0);
        check("R1 n enable", int'(n_out_en), 0);
        check("R1 lock", int'(locked), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", int'(p_out_en | n_out_en | locked), 0);

        // lock acquisition, hold and loss
        do_cmp(1'b1, 1, 1'b0);
        do_cmp(1'b0, 2, 1'b0);
        do_cmp(1'b1, 0, 1'b0);
        do_cmp(1'b1, 2, 1'b0);   // 4th good: R7 lock
        do_cmp(1'b0, 1, 1'b0);
        do_cmp(1'b1, 3, 1'b0);   // R8 wide clears
        do_cmp(1'b1, 1, 1'b0);
        do_cmp(1'b1, 1, 1'b0);
        do_cmp(1'b0, 0, 1'b0);
        do_cmp(1'b0, 4, 1'b1);   // R8 before run completes

        // sweep of separations and polarities
        for (int rep = 0; rep < 2; rep++) begin
            for (int d = 0; d <= 7; d++) begin
                for (int p = 0; p < 2; p++) begin
                    do_cmp(p[0], d, (d >= 3) ? 1'b1 : 1'b0);
                end
            end
        end
        // good run after the sweep re-locks
        for (int k = 0; k < 5; k++) do_cmp(k[0], k % 3, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule